// File: doc/BRIEF.md
# Big-Endian Byte/Word Memory Lane Unit

This block sits between a core's load/store stage and a data memory that is one 32-bit word wide. For each accepted request it forms the effective byte address by adding the base value and the sign-extended 16-bit displacement. It drives the word address to memory, together with per-byte write strobes and lane-positioned write data. When the request is a load, it takes the word that memory returns in the following cycle and extracts either the addressed byte or the whole word. The result is right-justified, and a byte result is either sign- or zero-extended.

Lanes are big-endian: the byte at offset 0 within a word is the most significant byte. A word request whose address is not a multiple of four raises a misalign flag and is not sent to memory. Address generation takes one register stage: memory-side outputs appear the cycle after the request. Load results appear one cycle later still, combinationally formatted from the memory read word in that cycle.

Top module: `be_lane_unit`

## Requirements
- R1: One cycle after a request with `req_valid_i`=1, `mem_addr_o` equals (`base_i` + sign-extended `disp_i`) shifted right by two. A negative displacement lowers the address.
- R2: A byte store at address offset k (address bits 1:0) asserts only strobe bit 3-k of `mem_be_o`: offset 0 gives 4'b1000, offset 3 gives 4'b0001.
- R3: A byte store places `reg_data_i[7:0]` on every byte lane of `mem_wdata_o`, so the single asserted strobe writes that byte and leaves the other three memory bytes unchanged.
- R4: An aligned word store drives `mem_be_o`=4'b1111 and `mem_wdata_o`=`reg_data_i`.
- R5: A word request (`req_word_i`=1) whose address bits 1:0 are not 00 gives `misalign_o`=1, `mem_be_o`=0 and `mem_req_o`=0 one cycle later, and no load result follows.
- R6: A byte load at offset k returns in bits 7:0 of `ld_data_o` the bits [31-8k : 24-8k] of `mem_rdata_i`.
- R7: A byte load with `req_signed_i`=1 copies bit 7 of the byte into bits 31:8, and with `req_signed_i`=0 bits 31:8 are zero.
- R8: An aligned word load returns `mem_rdata_i` unchanged in `ld_data_o`.
- R9: A load issues `mem_req_o`=1 with `mem_be_o`=0 one cycle after the request, and `ld_valid_o`=1 in the next cycle, with `ld_data_o` formed from `mem_rdata_i` of that cycle.
- R10: While `rst_n` is low, and in the first cycle after it, `mem_req_o`, `mem_be_o`, `misalign_o` and `ld_valid_o` are 0. A load in flight at reset produces no result.
- R11: When `req_valid_i`=0 the next cycle has `mem_req_o`=0, `mem_be_o`=0 and `misalign_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Request present this cycle |
| req_store_i | input | 1 | 1 = store, 0 = load |
| req_word_i | input | 1 | 1 = word access, 0 = byte access |
| req_signed_i | input | 1 | Byte load: 1 = sign-extend, 0 = zero-extend |
| base_i | input | 32 | Base register value |
| disp_i | input | 16 | Signed displacement |
| reg_data_i | input | 32 | Store source register |
| mem_rdata_i | input | 32 | Word returned by memory |
| mem_req_o | output | 1 | Memory access issued |
| mem_addr_o | output | 30 | Word address |
| mem_be_o | output | 4 | Byte write strobes, bit 3 = most significant lane |
| mem_wdata_o | output | 32 | Lane-positioned write data |
| misalign_o | output | 1 | Misaligned word request |
| ld_valid_o | output | 1 | Load result valid |
| ld_data_o | output | 32 | Right-justified, extended load result |

## Verification
Byte stores are issued at all four offsets, reached with positive, negative and large displacements. Each one shows that the strobe moves to the big-endian lane, and that the address carry into the word address is right. Byte loads are run with both signed and unsigned extension, using bytes with the top bit set and clear, so that sign extension, zero extension and the wrong-lane cases each give a different value. Aligned and misaligned word stores and loads separate full-word transfer from suppression. Idle cycles and a reset with a load in flight show that nothing is issued spuriously.

// File: rtl/be_lane_pkg.sv
// Package: shared access-size encoding for the big-endian lane unit.
package be_lane_pkg;
    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } acc_size_e;
endpackage

// File: rtl/be_lane_addr.sv
// Address and store-lane generator (combinational).
// Forms base + sign-extended displacement, flags misaligned word accesses,
// and maps the byte offset onto big-endian strobes and write data.
// Assumes DATA_W is a multiple of 8 and a power-of-two byte count.
module be_lane_addr #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [ADDR_W-1:0]        base,
    input  logic [DISP_W-1:0]        disp,
    input  logic                     is_store,
    input  logic                     is_word,
    input  logic [DATA_W-1:0]        reg_data,
    output logic [ADDR_W-LANE_W-1:0] word_addr,
    output logic [LANE_W-1:0]        lane,
    output logic                     misalign,
    output logic [BYTES-1:0]         strobe,
    output logic [DATA_W-1:0]        wdata
);
    logic [ADDR_W-1:0] eff_addr;

    // Effective address with sign-extended displacement.
    always_comb begin
        eff_addr = base + {{(ADDR_W-DISP_W){disp[DISP_W-1]}}, disp};
    end

    assign word_addr = eff_addr[ADDR_W-1:LANE_W];
    assign lane      = eff_addr[LANE_W-1:0];
    assign misalign  = is_word && (lane != '0);

    // One strobe and one data lane per byte; offset i maps to lane BYTES-1-i.
    for (genvar i = 0; i < BYTES; i++) begin : g_lane
        localparam logic [LANE_W-1:0] OFS = LANE_W'(i);
        assign strobe[BYTES-1-i] = is_store && !misalign && (is_word || lane == OFS);
        assign wdata[8*(BYTES-1-i) +: 8] = is_word ? reg_data[8*(BYTES-1-i) +: 8]
                                                   : reg_data[7:0];
    end
endmodule

// File: rtl/be_lane_load.sv
// Load formatter (combinational).
// Picks the byte at a big-endian offset, or passes the whole word, and
// right-justifies a byte with sign or zero extension.
module be_lane_load #(
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES)
) (
    input  logic [DATA_W-1:0] word,
    input  logic [LANE_W-1:0] lane,
    input  logic              is_byte,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] result
);
    logic [7:0] by_ofs [BYTES];
    logic [7:0] sel;

    // Offset i reads the i-th byte from the most significant end.
    for (genvar i = 0; i < BYTES; i++) begin : g_pick
        assign by_ofs[i] = word[8*(BYTES-1-i) +: 8];
    end

    // Select and extend.
    always_comb begin
        sel = by_ofs[lane];
        if (is_byte) begin
            result = {{(DATA_W-8){sign_ext & sel[7]}}, sel};
        end else begin
            result = word;
        end
    end
endmodule

// File: rtl/be_lane_unit.sv
// Top: big-endian byte/word memory lane unit.
// Stage 1 registers the memory request; stage 2 marks the load result, which
// is formatted from the memory read word of that cycle.
// Assumes memory returns read data the cycle after mem_req_o.
module be_lane_unit #(
    parameter int ADDR_W = 32,
    parameter int DISP_W = 16,
    parameter int DATA_W = 32,
    localparam int BYTES  = DATA_W / 8,
    localparam int LANE_W = $clog2(BYTES),
    localparam int WA_W   = ADDR_W - LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic              req_store_i,
    input  logic              req_word_i,
    input  logic              req_signed_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [DISP_W-1:0] disp_i,
    input  logic [DATA_W-1:0] reg_data_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_req_o,
    output logic [WA_W-1:0]   mem_addr_o,
    output logic [BYTES-1:0]  mem_be_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              misalign_o,
    output logic              ld_valid_o,
    output logic [DATA_W-1:0] ld_data_o
);
    import be_lane_pkg::*;

    logic [WA_W-1:0]   ag_addr;
    logic [LANE_W-1:0] ag_lane;
    logic              ag_mis;
    logic [BYTES-1:0]  ag_strobe;
    logic [DATA_W-1:0] ag_wdata;
    acc_size_e         req_size;

    logic              s1_load_q;
    logic [LANE_W-1:0] s1_lane_q;
    logic              s1_byte_q;
    logic              s1_sign_q;
    logic [LANE_W-1:0] ld_lane_q;
    logic              ld_byte_q;
    logic              ld_sign_q;
    logic [DATA_W-1:0] fmt_data;

    assign req_size = req_word_i ? SZ_WORD : SZ_BYTE;

    be_lane_addr #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .DATA_W(DATA_W)) i_addr (
        .base      (base_i),
        .disp      (disp_i),
        .is_store  (req_store_i),
        .is_word   (req_size == SZ_WORD),
        .reg_data  (reg_data_i),
        .word_addr (ag_addr),
        .lane      (ag_lane),
        .misalign  (ag_mis),
        .strobe    (ag_strobe),
        .wdata     (ag_wdata)
    );

    // Stage 1: register the memory-side request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_req_o   <= 1'b0;
            mem_addr_o  <= '0;
            mem_be_o    <= '0;
            mem_wdata_o <= '0;
            misalign_o  <= 1'b0;
            s1_load_q   <= 1'b0;
            s1_lane_q   <= '0;
            s1_byte_q   <= 1'b0;
            s1_sign_q   <= 1'b0;
        end else begin
            mem_req_o   <= req_valid_i && !ag_mis;
            mem_addr_o  <= ag_addr;
            mem_be_o    <= req_valid_i ? ag_strobe : '0;
            mem_wdata_o <= ag_wdata;
            misalign_o  <= req_valid_i && ag_mis;
            s1_load_q   <= req_valid_i && !ag_mis && !req_store_i;
            s1_lane_q   <= ag_lane;
            s1_byte_q   <= (req_size == SZ_BYTE);
            s1_sign_q   <= req_signed_i;
        end
    end

    // Stage 2: carry load context to the cycle read data arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid_o <= 1'b0;
            ld_lane_q  <= '0;
            ld_byte_q  <= 1'b0;
            ld_sign_q  <= 1'b0;
        end else begin
            ld_valid_o <= s1_load_q;
            ld_lane_q  <= s1_lane_q;
            ld_byte_q  <= s1_byte_q;
            ld_sign_q  <= s1_sign_q;
        end
    end

    be_lane_load #(.DATA_W(DATA_W)) i_load (
        .word     (mem_rdata_i),
        .lane     (ld_lane_q),
        .is_byte  (ld_byte_q),
        .sign_ext (ld_sign_q),
        .result   (fmt_data)
    );

    // Drive the result only while it is valid.
    always_comb begin
        ld_data_o = ld_valid_o ? fmt_data : '0;
    end
endmodule

// File: rtl/be_lane_unit_chk.sv
// Checker for be_lane_unit: temporal properties on its outputs and load context.
module be_lane_unit_chk #(
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic [BYTES-1:0]  mem_be_o,
    input logic              misalign_o,
    input logic              ld_valid_o,
    input logic [DATA_W-1:0] ld_data_o,
    input logic              ld_byte_q,
    input logic              ld_sign_q
);
    assert_misalign_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        misalign_o |-> (mem_be_o == '0 && !mem_req_o));

    assert_strobe_shape_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be_o != '0) |-> ($countones(mem_be_o) == 1 || mem_be_o == '1));

    assert_strobe_needs_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be_o != '0) |-> mem_req_o);

    assert_load_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid_o |-> $past(mem_req_o && mem_be_o == '0));

    assert_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_o && ld_byte_q && !ld_sign_q) |-> ld_data_o[DATA_W-1:8] == '0);

    assert_sign_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid_o && ld_byte_q && ld_sign_q) |->
            ld_data_o[DATA_W-1:8] == {(DATA_W-8){ld_data_o[7]}});
endmodule

bind be_lane_unit be_lane_unit_chk #(.DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_o  (mem_req_o),
    .mem_be_o   (mem_be_o),
    .misalign_o (misalign_o),
    .ld_valid_o (ld_valid_o),
    .ld_data_o  (ld_data_o),
    .ld_byte_q  (ld_byte_q),
    .ld_sign_q  (ld_sign_q)
);

// File: tb/test_be_lane_unit.sv
module test_be_lane_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0, req_store_i = 1'b0, req_word_i = 1'b0, req_signed_i = 1'b0;
    logic [31:0] base_i = '0;
    logic [15:0] disp_i = '0;
    logic [31:0] reg_data_i = '0, mem_rdata_i = '0;
    logic        mem_req_o, misalign_o, ld_valid_o;
    logic [29:0] mem_addr_o;
    logic [3:0]  mem_be_o;
    logic [31:0] mem_wdata_o, ld_data_o;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    be_lane_unit i_be_lane_unit (.*);

    typedef struct packed {
        logic        st;
        logic        wd;
        logic        sg;
        logic [31:0] base;
        logic [15:0] disp;
        logic [31:0] dat;   // store: register, load: memory word
        logic        mis;
        logic [29:0] wa;
        logic [3:0]  be;
        logic [31:0] res;   // store: write data, load: result
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 1'b0, 32'h1000_0000, 16'h0001, 32'h1234_56AB, 1'b0, 30'h0400_0000, 4'b0100, 32'hABAB_ABAB},
        '{1'b1, 1'b0, 1'b0, 32'h1000_0004, 16'hFFFF, 32'h0000_00CD, 1'b0, 30'h0400_0000, 4'b0001, 32'hCDCD_CDCD},
        '{1'b1, 1'b1, 1'b0, 32'h2000_0000, 16'h0008, 32'hDEAD_BEEF, 1'b0, 30'h0800_0002, 4'b1111, 32'hDEAD_BEEF},
        '{1'b1, 1'b1, 1'b0, 32'h2000_0000, 16'h0002, 32'hDEAD_BEEF, 1'b1, 30'h0,         4'b0000, 32'h0},
        '{1'b0, 1'b0, 1'b0, 32'h0000_0100, 16'h0000, 32'h8A12_3456, 1'b0, 30'h40,        4'b0000, 32'h0000_008A},
        '{1'b0, 1'b0, 1'b1, 32'h0000_0100, 16'h0000, 32'h8A12_3456, 1'b0, 30'h40,        4'b0000, 32'hFFFF_FF8A},
        '{1'b0, 1'b0, 1'b1, 32'h0000_0100, 16'h0002, 32'h8A12_3456, 1'b0, 30'h40,        4'b0000, 32'h0000_0034},
        '{1'b0, 1'b0, 1'b1, 32'h0000_0104, 16'hFFFF, 32'h0000_00F0, 1'b0, 30'h40,        4'b0000, 32'hFFFF_FFF0},
        '{1'b0, 1'b1, 1'b0, 32'h0000_0200, 16'hFFFC, 32'hCAFE_F00D, 1'b0, 30'h7F,        4'b0000, 32'hCAFE_F00D},
        '{1'b0, 1'b1, 1'b1, 32'h0000_0200, 16'h0001, 32'hCAFE_F00D, 1'b1, 30'h0,         4'b0000, 32'h0},
        '{1'b1, 1'b0, 1'b0, 32'h0000_0031, 16'h7FFF, 32'hFFFF_FF77, 1'b0, 30'h0000_200C, 4'b1000, 32'h7777_7777},
        '{1'b0, 1'b0, 1'b0, 32'h0000_0000, 16'h8001, 32'h00C3_0000, 1'b0, 30'h3FFF_E000, 4'b0000, 32'h0000_00C3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one request for one cycle; return just after the capturing edge.
    task automatic issue(input vec_t v);
        @(negedge clk);
        req_valid_i  = 1'b1;
        req_store_i  = v.st;
        req_word_i   = v.wd;
        req_signed_i = v.sg;
        base_i       = v.base;
        disp_i       = v.disp;
        reg_data_i   = v.st ? v.dat : 32'h5555_5555;
        @(negedge clk);
        req_valid_i  = 1'b0;
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        // R10: state while in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R10 req in reset", {31'b0, mem_req_o}, 32'h0);
        chk("R10 be in reset", {28'b0, mem_be_o}, 32'h0);
        chk("R10 misalign in reset", {31'b0, misalign_o}, 32'h0);
        chk("R10 ld_valid in reset", {31'b0, ld_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 first cycle after reset", {30'b0, mem_req_o, ld_valid_o}, 32'h0);

        // Vector table: R1..R9
        for (int i = 0; i < NV; i++) begin
            vec_t v = VECS[i];
            issue(v);
            chk($sformatf("R5 misalign v%0d", i), {31'b0, misalign_o}, {31'b0, v.mis});
            chk($sformatf("R9 mem_req v%0d", i), {31'b0, mem_req_o}, {31'b0, !v.mis});
            chk($sformatf("R2 strobes v%0d", i), {28'b0, mem_be_o}, {28'b0, v.be});
            if (!v.mis)
                chk($sformatf("R1 word address v%0d", i), {2'b0, mem_addr_o}, {2'b0, v.wa});
            if (v.st && !v.mis)
                chk($sformatf("R3 write data v%0d", i), mem_wdata_o, v.res);
            mem_rdata_i = v.st ? 32'h0 : v.dat;
            @(negedge clk);
            chk($sformatf("R9 ld_valid v%0d", i), {31'b0, ld_valid_o}, {31'b0, !v.st && !v.mis});
            if (!v.st && !v.mis)
                chk($sformatf("R6 load result v%0d", i), ld_data_o, v.res);
        end

        // R11: inputs present but req_valid_i low
        @(negedge clk);
        req_store_i = 1'b1; req_word_i = 1'b1; base_i = 32'h3; disp_i = 16'h0;
        reg_data_i = 32'hFFFF_FFFF;
        @(negedge clk);
        chk("R11 idle req", {31'b0, mem_req_o}, 32'h0);
        chk("R11 idle be", {28'b0, mem_be_o}, 32'h0);
        chk("R11 idle misalign", {31'b0, misalign_o}, 32'h0);

        // R8: word load result follows the read word of that cycle
        issue('{1'b0, 1'b1, 1'b0, 32'h40, 16'h0, 32'h0, 1'b0, 30'h10, 4'b0, 32'h0});
        mem_rdata_i = 32'h0102_0304;
        @(negedge clk);
        chk("R8 word load", ld_data_o, 32'h0102_0304);

        // R10: reset with a load in flight
        issue('{1'b0, 1'b0, 1'b1, 32'h40, 16'h0, 32'h0, 1'b0, 30'h10, 4'b0, 32'h0});
        rst_n = 1'b0;
        @(negedge clk);
        chk("R10 load dropped by reset", {31'b0, ld_valid_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 no load after reset", {31'b0, ld_valid_o}, 32'h0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule